// File: doc/BRIEF.md
# Interval-Tagged Reservation Buffer

This block holds the pending circuit reservations of one router port and presents, at every cycle, the reservation that must be realized next. Each reservation carries an expected-use time made of a 2-bit interval tag and a cycle count inside that interval, plus the destination node and the request id of the circuit's owner. An internal cycle counter runs from zero to the interval length minus one and then wraps. On every wrap all stored tags age by one interval. Entries that age past the oldest dated interval drop their cycle count and join an undated catch-all class. That class keeps its own arrival order and is always served first.

Inserts arrive on a valid/ready stream. `ins_ready` depends only on occupancy: it is low exactly when the buffer is full. An insert whose tag would land in the catch-all class raises `ins_err` in the same cycle and is never stored. The producer may drop it in that cycle. The head leaves on a valid/ready stream. While `out_ready` is low, the presented head may change because of a wrap or an earlier-ranked insert. The consumer takes whatever is shown in the cycle it raises `out_ready`.

Tag encoding, used at both ports: 0 = catch-all (oldest), 1 = previous interval, 2 = current interval, 3 = next interval.

Top module: `rsv_interval_buffer`

## Requirements
- R1: `now_cyc` is 0 after reset and counts up by one per clock. `wrap` is high in the cycle where `now_cyc` equals T_LEN-1, and `now_cyc` is 0 in the cycle after that.
- R2: A stored entry's tag changes only at a wrap edge. At that edge it drops by one, and tag 0 stays at 0.
- R3: With no catch-all entries present, the head is the entry with the smallest {tag, cycle, destination, request id}, compared as one unsigned number with tag as the most significant part.
- R4: While any tag-0 entry is stored, the head has tag 0, whatever dated entries are also present.
- R5: Entries reaching tag 0 at the same wrap are ordered among themselves by {cycle, destination, request id} and follow every entry already at tag 0. A tag-0 entry shows cycle 0 on `out_cyc`.
- R6: An insert with tag 0, or with tag 1 in a cycle where `wrap` is high, raises `ins_err` in that cycle and is not stored.
- R7: When DEPTH entries are held, `full` is high and `ins_ready` is low, and an offered insert is not stored.
- R8: An insert accepted in a `wrap` cycle has its tag taken relative to the interval that is ending, and it is stored already aged by one.
- R9: `out_valid` is high exactly when at least one entry is stored. On `out_valid && out_ready`, the presented entry is removed at that clock edge.
- R10: A removal and an insert in the same cycle both take effect. A slot freed by that removal is not reused in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert offered |
| ins_ready | output | 1 | Buffer can accept an insert (not full) |
| ins_tag | input | 2 | Interval tag of the insert |
| ins_cyc | input | clog2(T_LEN) | Cycle within that interval |
| ins_dst | input | DST_W | Destination node |
| ins_rid | input | RID_W | Request id |
| ins_err | output | 1 | Insert would fall in the catch-all class |
| full | output | 1 | All slots occupied |
| out_valid | output | 1 | A head reservation is presented |
| out_ready | input | 1 | Consumer takes the head |
| out_tag | output | 2 | Head tag |
| out_cyc | output | clog2(T_LEN) | Head cycle (0 for catch-all) |
| out_dst | output | DST_W | Head destination |
| out_rid | output | RID_W | Head request id |
| now_cyc | output | clog2(T_LEN) | Cycle count in the current interval |
| wrap | output | 1 | Last cycle of the current interval |

## Verification
Two functions can meet on one edge. The interval wrap can coincide with an insert, which tests the tag-1 rejection and pre-aged storage. It can also coincide with a head removal, where a popped tag-1 entry must not be promoted and the new catch-all ranks must account for a departing catch-all head. Directed steps wait for the last cycle of an interval and then insert or pop there. A long stretch of random traffic then makes these meetings often. A behavioural model, built from a dated list and an ordered catch-all queue, predicts every output on every clock, and each mismatch is reported against the requirement it concerns.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // Interval tag encoding: smaller value is realized earlier.
  typedef enum logic [1:0] {
    TAG_OLD  = 2'd0,
    TAG_PREV = 2'd1,
    TAG_CUR  = 2'd2,
    TAG_NEXT = 2'd3
  } itag_e;
endpackage

// File: rtl/rsv_interval_clock.sv
module rsv_interval_clock #(
  parameter int T_LEN = 16,
  parameter int CYC_W = $clog2(T_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CYC_W-1:0] now_cyc,
  output logic             wrap
);
  assign wrap = (now_cyc == CYC_W'(T_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    now_cyc <= '0;
    else if (wrap) now_cyc <= '0;
    else           now_cyc <= now_cyc + CYC_W'(1);
  end

  AST_CLK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (now_cyc == '0)); // R1
endmodule

// File: rtl/rsv_pick.sv
// Finds the valid entry with the smallest key; lowest index wins on equal keys.
module rsv_pick #(
  parameter int N     = 8,
  parameter int KEY_W = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vld,
  input  logic [KEY_W-1:0] key [N],
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [KEY_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (!any || key[i] < best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = key[i];
      end
    end
  end
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot
  import rsv_pkg::*;
#(
  parameter int CYC_W = 4,
  parameter int DST_W = 3,
  parameter int RID_W = 2,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             age,
  input  logic             promote,
  input  logic [IDX_W-1:0] new_rank,
  input  logic             dec_rank,
  input  logic             wr,
  input  logic [1:0]       wr_tag,
  input  logic [CYC_W-1:0] wr_cyc,
  input  logic [DST_W-1:0] wr_dst,
  input  logic [RID_W-1:0] wr_rid,
  output logic             vld,
  output logic [1:0]       tag,
  output logic [CYC_W-1:0] cyc,
  output logic [DST_W-1:0] dst,
  output logic [RID_W-1:0] rid,
  output logic [IDX_W-1:0] rank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      tag  <= TAG_OLD;
      cyc  <= '0;
      dst  <= '0;
      rid  <= '0;
      rank <= '0;
    end else if (clr) begin
      vld <= 1'b0;
    end else if (wr) begin
      vld  <= 1'b1;
      tag  <= wr_tag;
      cyc  <= wr_cyc;
      dst  <= wr_dst;
      rid  <= wr_rid;
      rank <= '0;
    end else if (vld) begin
      if (age && tag != TAG_OLD) tag <= tag - 2'd1;
      if (promote) begin
        rank <= new_rank;
        cyc  <= '0;
      end else if (dec_rank) begin
        rank <= rank - IDX_W'(1);
      end
    end
  end

  AST_SLOT_WR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (!vld && !clr)); // R10
  AST_OLD_NO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && tag == TAG_OLD) |-> (cyc == '0)); // R5
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !age && !clr) |=> (tag == $past(tag))); // R2
endmodule

// File: rtl/rsv_interval_buffer.sv
module rsv_interval_buffer
  import rsv_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int T_LEN = 16,
  parameter int DST_W = 3,
  parameter int RID_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [1:0]               ins_tag,
  input  logic [$clog2(T_LEN)-1:0] ins_cyc,
  input  logic [DST_W-1:0]         ins_dst,
  input  logic [RID_W-1:0]         ins_rid,
  output logic                     ins_err,
  output logic                     full,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [1:0]               out_tag,
  output logic [$clog2(T_LEN)-1:0] out_cyc,
  output logic [DST_W-1:0]         out_dst,
  output logic [RID_W-1:0]         out_rid,
  output logic [$clog2(T_LEN)-1:0] now_cyc,
  output logic                     wrap
);
  localparam int CYC_W = $clog2(T_LEN);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LO_W  = CYC_W + DST_W + RID_W;
  localparam int KEY_W = 2 + LO_W;

  logic [DEPTH-1:0] e_vld;
  logic [1:0]       e_tag  [DEPTH];
  logic [CYC_W-1:0] e_cyc  [DEPTH];
  logic [DST_W-1:0] e_dst  [DEPTH];
  logic [RID_W-1:0] e_rid  [DEPTH];
  logic [IDX_W-1:0] e_rank [DEPTH];
  logic [LO_W-1:0]  lo_key [DEPTH];
  logic [KEY_W-1:0] sel_key[DEPTH];
  logic [IDX_W-1:0] new_rank[DEPTH];
  logic [IDX_W-1:0] head_idx, free_idx;
  logic [DEPTH-1:0] clr_v, promo_v, dec_v, wr_v, old_v;
  logic             pop, head_old, bad, store, rank_ok;
  logic [CNT_W-1:0] old_cnt, occ, base_rank;
  logic [1:0]       wr_tag;

  rsv_interval_clock #(.T_LEN(T_LEN), .CYC_W(CYC_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .now_cyc(now_cyc), .wrap(wrap)
  );

  rsv_pick #(.N(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_pick (
    .vld(e_vld), .key(sel_key), .any(out_valid), .idx(head_idx)
  );

  // Occupancy and catch-all population.
  always_comb begin
    occ     = '0;
    old_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      occ     = occ + CNT_W'(e_vld[i]);
      old_cnt = old_cnt + CNT_W'(old_v[i]);
    end
  end

  // Lowest free slot.
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!e_vld[i]) free_idx = IDX_W'(i);
  end

  assign pop       = out_valid && out_ready;
  assign head_old  = pop && (e_tag[head_idx] == TAG_OLD);
  assign base_rank = old_cnt - CNT_W'(head_old);
  assign full      = &e_vld;
  assign ins_ready = !full;
  assign bad       = (ins_tag == TAG_OLD) || (ins_tag == TAG_PREV && wrap);
  assign ins_err   = ins_valid && bad;
  assign store     = ins_valid && !full && !bad;
  assign wr_tag    = wrap ? ins_tag - 2'd1 : ins_tag;

  assign out_tag = e_tag[head_idx];
  assign out_cyc = e_cyc[head_idx];
  assign out_dst = e_dst[head_idx];
  assign out_rid = e_rid[head_idx];

  // Ranks for entries joining the catch-all class at this wrap.
  always_comb begin : rank_calc
    logic [CNT_W-1:0] acc;
    for (int i = 0; i < DEPTH; i++) begin
      acc = base_rank;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && promo_v[j] &&
            (lo_key[j] < lo_key[i] || (lo_key[j] == lo_key[i] && j < i)))
          acc = acc + CNT_W'(1);
      end
      new_rank[i] = acc[IDX_W-1:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      assign lo_key[g]  = {e_cyc[g], e_dst[g], e_rid[g]};
      assign sel_key[g] = {e_tag[g], (e_tag[g] == TAG_OLD) ? LO_W'(e_rank[g]) : lo_key[g]};
      assign old_v[g]   = e_vld[g] && (e_tag[g] == TAG_OLD);
      assign clr_v[g]   = pop && (head_idx == IDX_W'(g));
      assign promo_v[g] = wrap && e_vld[g] && (e_tag[g] == TAG_PREV) && !clr_v[g];
      assign dec_v[g]   = head_old && old_v[g] && !clr_v[g];
      assign wr_v[g]    = store && (free_idx == IDX_W'(g));

      rsv_slot #(.CYC_W(CYC_W), .DST_W(DST_W), .RID_W(RID_W), .IDX_W(IDX_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .clr(clr_v[g]), .age(wrap), .promote(promo_v[g]), .new_rank(new_rank[g]),
        .dec_rank(dec_v[g]), .wr(wr_v[g]), .wr_tag(wr_tag), .wr_cyc(ins_cyc),
        .wr_dst(ins_dst), .wr_rid(ins_rid),
        .vld(e_vld[g]), .tag(e_tag[g]), .cyc(e_cyc[g]), .dst(e_dst[g]),
        .rid(e_rid[g]), .rank(e_rank[g])
      );
    end
  endgenerate

  // Catch-all ranks must be distinct and dense.
  always_comb begin
    rank_ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (old_v[i] && CNT_W'(e_rank[i]) >= old_cnt) rank_ok = 1'b0;
      for (int j = i + 1; j < DEPTH; j++)
        if (old_v[i] && old_v[j] && e_rank[i] == e_rank[j]) rank_ok = 1'b0;
    end
  end

  AST_OLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && old_cnt != '0) |-> (out_tag == TAG_OLD)); // R4
  AST_OLD_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
    rank_ok); // R5
  AST_OLD_ONLY_BY_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    (old_cnt > $past(old_cnt)) |-> $past(wrap)); // R6
  AST_ERR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |=> (occ <= $past(occ))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(full) && !$past(pop)) |-> (occ <= $past(occ))); // R7
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (occ != '0)); // R9
endmodule

// File: tb/test_rsv_interval_buffer.sv
`timescale 1ns/1ps
module test_rsv_interval_buffer;
  localparam int DEPTH = 8;
  localparam int T_LEN = 16;
  localparam int DST_W = 3;
  localparam int RID_W = 2;
  localparam int CYC_W = $clog2(T_LEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready, ins_err, full, out_valid, out_ready = 1'b0, wrap;
  logic [1:0] ins_tag = '0, out_tag;
  logic [CYC_W-1:0] ins_cyc = '0, out_cyc, now_cyc;
  logic [DST_W-1:0] ins_dst = '0, out_dst;
  logic [RID_W-1:0] ins_rid = '0, out_rid;

  always #4 clk = ~clk;

  rsv_interval_buffer #(.DEPTH(DEPTH), .T_LEN(T_LEN), .DST_W(DST_W), .RID_W(RID_W))
  i_rsv_interval_buffer (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_tag(ins_tag), .ins_cyc(ins_cyc), .ins_dst(ins_dst), .ins_rid(ins_rid),
    .ins_err(ins_err), .full(full), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_cyc(out_cyc), .out_dst(out_dst), .out_rid(out_rid),
    .now_cyc(now_cyc), .wrap(wrap)
  );

  typedef struct {int tag; int cyc; int dst; int rid;} ent_t;
  ent_t nq[$];   // dated entries
  ent_t oq[$];   // catch-all, in service order
  int mnow = 0;
  int checks = 0, fails = 0;
  bit prev_wrap_store = 0, prev_pop_ins = 0, done = 0;

  function automatic longint keyof(ent_t e);
    return ((longint'(e.tag) * T_LEN + e.cyc) * (1 << DST_W) + e.dst) * (1 << RID_W) + e.rid;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, settle, compare against the model, advance the model.
  task automatic tick(bit iv, int tg, int c, int d, int r, bit ordy);
    int occ, hi;
    bit wr, bad, exf, hov, pop, store;
    ent_t h, keep[$], pro[$];
    string lbl;
    ins_valid = iv; ins_tag = tg[1:0]; ins_cyc = c[CYC_W-1:0];
    ins_dst = d[DST_W-1:0]; ins_rid = r[RID_W-1:0]; out_ready = ordy;
    #1;
    occ = nq.size() + oq.size();
    wr  = (mnow == T_LEN - 1);
    exf = (occ == DEPTH);
    bad = (tg == 0) || (tg == 1 && wr);
    hov = (occ > 0);
    chk("R1 now_cyc", int'(now_cyc), mnow);
    chk("R1 wrap", int'(wrap), int'(wr));
    chk("R7 full", int'(full), int'(exf));
    chk("R7 ins_ready", int'(ins_ready), int'(!exf));
    chk("R6 ins_err", int'(ins_err), int'(iv && bad));
    chk("R9 out_valid", int'(out_valid), int'(hov));
    hi = -1;
    if (hov) begin
      if (oq.size() > 0) begin
        h = oq[0];
        lbl = (nq.size() > 0) ? "R4 catch-all first" : "R5 catch-all order";
      end else begin
        hi = 0;
        foreach (nq[k]) if (keyof(nq[k]) < keyof(nq[hi])) hi = k;
        h = nq[hi];
        lbl = prev_wrap_store ? "R8 pre-aged insert" : "R3 dated order";
      end
      if (prev_pop_ins) lbl = "R10 pop with insert";
      chk("R2 out_tag", int'(out_tag), h.tag);
      chk(lbl, int'(out_cyc), h.cyc);
      chk(lbl, int'(out_dst), h.dst);
      chk(lbl, int'(out_rid), h.rid);
    end
    pop = hov && ordy;
    if (pop) begin
      if (hi < 0) void'(oq.pop_front());
      else nq.delete(hi);
    end
    if (wr) begin
      foreach (nq[k]) begin
        ent_t e = nq[k];
        if (e.tag == 1) pro.push_back(e);
        else begin e.tag--; keep.push_back(e); end
      end
      for (int a = 1; a < pro.size(); a++)
        for (int b = a; b > 0 && keyof(pro[b]) < keyof(pro[b-1]); b--) begin
          ent_t t = pro[b]; pro[b] = pro[b-1]; pro[b-1] = t;
        end
      foreach (pro[k]) begin
        ent_t e = pro[k];
        e.tag = 0; e.cyc = 0;
        oq.push_back(e);
      end
      nq = keep;
    end
    store = iv && !exf && !bad;
    if (store) begin
      ent_t e;
      e.tag = wr ? tg - 1 : tg; e.cyc = c; e.dst = d; e.rid = r;
      nq.push_back(e);
    end
    prev_wrap_store = wr && store;
    prev_pop_ins    = pop && store;
    mnow = wr ? 0 : mnow + 1;
    @(negedge clk);
  endtask

  task automatic idle(bit ordy);
    tick(0, 2, 0, 0, 0, ordy);
  endtask

  task automatic to_last(bit ordy);
    while (mnow != T_LEN - 1) idle(ordy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset now_cyc", int'(now_cyc), 0);
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R7 reset full", int'(full), 0);
    @(negedge clk);
    mnow = 1;

    // Fill with ties on cycle, then on destination; offer one more when full.
    for (int k = 0; k < DEPTH; k++)
      tick(1, 3, (k < 4) ? 5 : 9 - k, (k < 2) ? 1 : 7 - k, 3 - (k % 4), 0);
    tick(1, 2, 1, 1, 1, 0);   // R7: refused while full
    for (int k = 0; k < DEPTH + 2; k++) idle(1);

    // R6: tag 0 always refused; tag 1 refused in the wrap cycle.
    tick(1, 0, 3, 2, 1, 0);
    to_last(0);
    tick(1, 1, 4, 4, 0, 0);
    // R8: tag 2 accepted in the wrap cycle, stored as tag 1.
    to_last(0);
    tick(1, 2, 7, 3, 2, 0);
    idle(0);

    // R5: two batches into the catch-all class, then dated entries behind them.
    tick(1, 1, 9, 2, 0, 0);
    tick(1, 1, 2, 6, 1, 0);
    tick(1, 1, 2, 5, 3, 0);
    to_last(0); idle(0);
    tick(1, 1, 1, 0, 0, 0);
    tick(1, 2, 0, 1, 1, 0);
    tick(1, 3, 3, 1, 2, 0);
    to_last(0); idle(0);
    // Pop in a wrap cycle while a tag-1 entry waits.
    tick(1, 2, 5, 5, 1, 0);
    to_last(0);
    tick(0, 2, 0, 0, 0, 1);
    for (int k = 0; k < DEPTH + 2; k++) idle(1);

    // Random traffic.
    for (int k = 0; k < 4000; k++)
      tick(($urandom % 3) != 0, $urandom % 4, $urandom % T_LEN,
           $urandom % (1 << DST_W), $urandom % (1 << RID_W), ($urandom % 4) == 0);
    for (int k = 0; k < 3 * T_LEN; k++) idle(1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule